// File: doc/BRIEF.md
# Burst Word Order Address Generator

This block produces the word address for each data phase of a memory burst. When a new burst begins it captures the start address, a cache line size given in words and a requested ordering. It then presents the first word address and moves to the next address each time the bus accepts a data phase. Three orderings are available. Linear ordering counts straight up through memory. Wrap ordering and toggle ordering both begin with the critical word and stay inside one cache line until every word of that line has been used. Each ordering then moves to the same starting offset in the next line.

The generator also decides how a burst must end. A wrap or toggle burst with a line size that the block does not support is cut down to one word. A burst that asks for the reserved ordering code is marked to terminate after its first word. The bus handshake that uses these flags is outside this block.

Top module: `burst_order_agen`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `burst_valid`, `single_word` and `term_first` are low.
- R2: When `start` is high at a clock edge, `burst_valid` is high in the next cycle and `word_addr` equals the `start_addr` captured at that edge. This also applies while an earlier burst is still in progress, and `start` takes priority over `advance` in the same cycle.
- R3: While `burst_valid` is high and neither `advance` nor `start` is high, `word_addr` and `burst_valid` keep their values.
- R4: Ordering code 00 (linear): each accepted advance adds one to `word_addr` and ignores cache line boundaries. `line_words` has no effect, so `single_word` stays low even for unsupported sizes.
- R5: Ordering code 10 (wrap): after k accepted advances within a line of L words, `word_addr` equals the line base plus ((start offset + k) mod L).
- R6: Ordering code 01 (toggle): after k accepted advances within a line, `word_addr` equals the line base plus (start offset XOR k).
- R7: In wrap and toggle orderings, after L advances the line base grows by L and the sequence repeats from the original start offset in that next line.
- R8: When the start offset within the line is zero, all three orderings give the same address sequence (start, start+1, start+2, ...).
- R9: Supported `line_words` values are 4, 8, 16 and 32. For any other value with ordering 01 or 10, `single_word` is high while the burst is valid, and `burst_valid` drops in the cycle after the first accepted advance.
- R10: Ordering code 11 is unsupported. `term_first` is high while the burst is valid, `single_word` stays low, and `burst_valid` drops in the cycle after the first accepted advance.
- R11: An `advance` while `burst_valid` is low has no effect. `burst_valid` stays low until the next `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a new burst with the inputs below |
| start_addr | input | ADDR_W | Word address of the first (critical) word |
| order_sel | input | 2 | Ordering: 00 linear, 01 toggle, 10 wrap, 11 unsupported |
| line_words | input | LW_W | Cache line size in words |
| advance | input | 1 | Current data phase accepted; step to the next word |
| word_addr | output | ADDR_W | Address of the current word |
| burst_valid | output | 1 | A burst is active and `word_addr` is meaningful |
| single_word | output | 1 | Unsupported line size forces a one-word access |
| term_first | output | 1 | Unsupported ordering forces termination after the first word |

## Verification
The phase counter, the stored start offset and the line base all appear directly in `word_addr`. A fault in any of them therefore shows up on the first advance that depends on it. An in-line offset error appears within a few advances. A fault in line-end detection or in the line base increment appears exactly L advances after the start, so bursts are run beyond several whole lines for every supported size. Bursts with nonzero start offsets separate wrap from toggle, and zero-offset bursts confirm that the three orderings agree. Flag and end-of-burst faults appear one cycle after the first advance as `burst_valid` staying high or dropping at the wrong time.

// File: rtl/bwo_pkg.sv
package bwo_pkg;

  typedef enum logic [1:0] {
    ORD_LINEAR = 2'b00,
    ORD_TOGGLE = 2'b01,
    ORD_WRAP   = 2'b10,
    ORD_BAD    = 2'b11
  } order_e;

endpackage

// File: rtl/bwo_cfg_decode.sv
module bwo_cfg_decode
  import bwo_pkg::*;
#(
  parameter int LW_W   = 6,
  parameter int MIN_LG = 2,
  parameter int MAX_LG = 5,
  parameter int LG_W   = 3
) (
  input  logic [LW_W-1:0] line_words,
  input  order_e          order,
  output logic [LG_W-1:0] line_lg,
  output logic            single_req,
  output logic            term_req
);

  localparam int N_SIZES = MAX_LG - MIN_LG + 1;

  logic [N_SIZES-1:0] size_hit;
  logic               size_ok;

  // one comparator per supported power-of-two line size
  for (genvar g = 0; g < N_SIZES; g++) begin : g_size
    assign size_hit[g] = (line_words == (LW_W'(1) << (g + MIN_LG)));
  end

  always_comb begin
    line_lg = LG_W'(MIN_LG);
    for (int g = 0; g < N_SIZES; g++) begin
      if (size_hit[g]) line_lg = LG_W'(g + MIN_LG);
    end
  end

  assign size_ok    = |size_hit;
  assign term_req   = (order == ORD_BAD);
  assign single_req = !term_req && (order != ORD_LINEAR) && !size_ok;

endmodule

// File: rtl/bwo_seq_state.sv
module bwo_seq_state
  import bwo_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 5,
  parameter int LG_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  order_e            order,
  input  logic [LG_W-1:0]   line_lg,
  input  logic              single_req,
  input  logic              term_req,
  input  logic              advance,
  output logic              valid_q,
  output order_e            order_q,
  output logic [LG_W-1:0]   lg_q,
  output logic [ADDR_W-1:0] base_q,
  output logic [OFS_W-1:0]  off0_q,
  output logic [OFS_W-1:0]  phase_q,
  output logic [ADDR_W-1:0] lin_q,
  output logic              single_q,
  output logic              term_q
);

  function automatic logic [OFS_W-1:0] lo_mask(input logic [LG_W-1:0] lg);
    logic [OFS_W:0] m;
    m = ((OFS_W+1)'(1) << lg) - (OFS_W+1)'(1);
    return m[OFS_W-1:0];
  endfunction

  function automatic logic [ADDR_W-1:0] line_base(input logic [ADDR_W-1:0] a,
                                                  input logic [LG_W-1:0]   lg);
    return a & ~{{(ADDR_W-OFS_W){1'b0}}, lo_mask(lg)};
  endfunction

  logic step;
  logic line_done;
  logic burst_end;
  logic in_line_order;

  assign step          = valid_q && advance && !start;
  assign in_line_order = (order_q == ORD_WRAP) || (order_q == ORD_TOGGLE);
  assign line_done     = step && in_line_order && (phase_q == lo_mask(lg_q));
  assign burst_end     = step && (single_q || term_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      order_q  <= ORD_LINEAR;
      lg_q     <= '0;
      base_q   <= '0;
      off0_q   <= '0;
      phase_q  <= '0;
      lin_q    <= '0;
      single_q <= 1'b0;
      term_q   <= 1'b0;
    end else if (start) begin
      valid_q  <= 1'b1;
      order_q  <= order;
      lg_q     <= line_lg;
      base_q   <= line_base(start_addr, line_lg);
      off0_q   <= start_addr[OFS_W-1:0] & lo_mask(line_lg);
      phase_q  <= '0;
      lin_q    <= start_addr;
      single_q <= single_req;
      term_q   <= term_req;
    end else if (step) begin
      lin_q <= lin_q + ADDR_W'(1);
      if (line_done) begin
        base_q  <= base_q + (ADDR_W'(1) << lg_q);
        phase_q <= '0;
      end else begin
        phase_q <= phase_q + OFS_W'(1);
      end
      if (burst_end) valid_q <= 1'b0;
    end
  end

endmodule

// File: rtl/bwo_addr_mux.sv
module bwo_addr_mux
  import bwo_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 5,
  parameter int LG_W   = 3
) (
  input  order_e            order_q,
  input  logic [LG_W-1:0]   lg_q,
  input  logic [ADDR_W-1:0] base_q,
  input  logic [OFS_W-1:0]  off0_q,
  input  logic [OFS_W-1:0]  phase_q,
  input  logic [ADDR_W-1:0] lin_q,
  input  logic              single_q,
  output logic [ADDR_W-1:0] addr
);

  function automatic logic [OFS_W-1:0] wrap_ofs(input logic [OFS_W-1:0] o0,
                                                input logic [OFS_W-1:0] k,
                                                input logic [LG_W-1:0]  lg);
    logic [OFS_W:0] m;
    m = ((OFS_W+1)'(1) << lg) - (OFS_W+1)'(1);
    return (o0 + k) & m[OFS_W-1:0];
  endfunction

  function automatic logic [OFS_W-1:0] tog_ofs(input logic [OFS_W-1:0] o0,
                                               input logic [OFS_W-1:0] k);
    return o0 ^ k;
  endfunction

  logic [OFS_W-1:0] ofs;

  always_comb begin
    ofs  = '0;
    addr = lin_q;
    if (!single_q) begin
      unique case (order_q)
        ORD_WRAP: begin
          ofs  = wrap_ofs(off0_q, phase_q, lg_q);
          addr = base_q | ADDR_W'(ofs);
        end
        ORD_TOGGLE: begin
          ofs  = tog_ofs(off0_q, phase_q);
          addr = base_q | ADDR_W'(ofs);
        end
        default: addr = lin_q;
      endcase
    end
  end

endmodule

// File: rtl/burst_order_agen.sv
module burst_order_agen
  import bwo_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LW_W   = 6,
  parameter int MIN_LG = 2,
  parameter int MAX_LG = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [1:0]        order_sel,
  input  logic [LW_W-1:0]   line_words,
  input  logic              advance,
  output logic [ADDR_W-1:0] word_addr,
  output logic              burst_valid,
  output logic              single_word,
  output logic              term_first
);

  localparam int OFS_W = MAX_LG;
  localparam int LG_W  = $clog2(MAX_LG + 1);

  order_e            order_in;
  order_e            order_q;
  logic [LG_W-1:0]   line_lg;
  logic [LG_W-1:0]   lg_q;
  logic              single_req;
  logic              term_req;
  logic              valid_q;
  logic [ADDR_W-1:0] base_q;
  logic [OFS_W-1:0]  off0_q;
  logic [OFS_W-1:0]  phase_q;
  logic [ADDR_W-1:0] lin_q;
  logic              single_q;
  logic              term_q;
  logic [1:0]        mode_q;

  assign order_in = order_e'(order_sel);
  assign mode_q   = order_q;

  bwo_cfg_decode #(
    .LW_W(LW_W), .MIN_LG(MIN_LG), .MAX_LG(MAX_LG), .LG_W(LG_W)
  ) u_dec (
    .line_words (line_words),
    .order      (order_in),
    .line_lg    (line_lg),
    .single_req (single_req),
    .term_req   (term_req)
  );

  bwo_seq_state #(
    .ADDR_W(ADDR_W), .OFS_W(OFS_W), .LG_W(LG_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_addr (start_addr),
    .order      (order_in),
    .line_lg    (line_lg),
    .single_req (single_req),
    .term_req   (term_req),
    .advance    (advance),
    .valid_q    (valid_q),
    .order_q    (order_q),
    .lg_q       (lg_q),
    .base_q     (base_q),
    .off0_q     (off0_q),
    .phase_q    (phase_q),
    .lin_q      (lin_q),
    .single_q   (single_q),
    .term_q     (term_q)
  );

  bwo_addr_mux #(
    .ADDR_W(ADDR_W), .OFS_W(OFS_W), .LG_W(LG_W)
  ) u_mux (
    .order_q  (order_q),
    .lg_q     (lg_q),
    .base_q   (base_q),
    .off0_q   (off0_q),
    .phase_q  (phase_q),
    .lin_q    (lin_q),
    .single_q (single_q),
    .addr     (word_addr)
  );

  assign burst_valid = valid_q;
  assign single_word = valid_q && single_q;
  assign term_first  = valid_q && term_q;

endmodule

// File: rtl/bwo_chk.sv
module bwo_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [ADDR_W-1:0] start_addr,
  input logic              advance,
  input logic [ADDR_W-1:0] word_addr,
  input logic              burst_valid,
  input logic              single_word,
  input logic              term_first,
  input logic [1:0]        mode_q
);

  // R2
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> burst_valid && (word_addr == $past(start_addr)));

  // R3
  hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_valid && !advance && !start |=> burst_valid && $stable(word_addr));

  // R4
  linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_valid && advance && !start && (mode_q == 2'b00)
      |=> word_addr == $past(word_addr) + ADDR_W'(1));

  // R10
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(single_word && term_first));

  // R9
  one_word_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_valid && advance && !start && (single_word || term_first) |=> !burst_valid);

  // R11
  idle_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !burst_valid && !start |=> !burst_valid);

endmodule

bind burst_order_agen bwo_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .start_addr  (start_addr),
  .advance     (advance),
  .word_addr   (word_addr),
  .burst_valid (burst_valid),
  .single_word (single_word),
  .term_first  (term_first),
  .mode_q      (mode_q)
);

// File: tb/burst_order_agen_tb.sv
module burst_order_agen_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [31:0] start_addr;
  logic [1:0]  order_sel;
  logic [5:0]  line_words;
  logic        advance;
  logic [31:0] word_addr;
  logic        burst_valid;
  logic        single_word;
  logic        term_first;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  burst_order_agen u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .order_sel(order_sel), .line_words(line_words), .advance(advance),
    .word_addr(word_addr), .burst_valid(burst_valid),
    .single_word(single_word), .term_first(term_first)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit size_ok(input int lw);
    return lw == 4 || lw == 8 || lw == 16 || lw == 32;
  endfunction

  // expected address of word n, written from the ordering rules
  function automatic logic [31:0] model(input logic [31:0] s, input logic [1:0] m,
                                        input int lw, input int n);
    logic [31:0] len, off0, k, line, base, off;
    if (m == 2'b00) return s + 32'(n);
    len  = 32'(lw);
    off0 = s % len;
    line = 32'(n) / len;
    k    = 32'(n) % len;
    base = (s - off0) + line * len;
    off  = (m == 2'b10) ? (off0 + k) % len : (off0 ^ k);
    return base + off;
  endfunction

  task automatic run_burst(input logic [31:0] s, input logic [1:0] m,
                           input int lw, input int n, input string tag);
    bit sw  = (m == 2'b01 || m == 2'b10) && !size_ok(lw);
    bit tf  = (m == 2'b11);
    bit one = sw || tf;
    int i   = 0;
    bit adv;
    logic [31:0] exp;
    start = 1'b1; start_addr = s; order_sel = m; line_words = 6'(lw);
    advance = ($urandom % 2) == 1;  // ignored: start has priority
    @(posedge clk); #1;
    start = 1'b0;
    while (i < n) begin
      adv = ($urandom % 4) != 0;
      advance = adv;
      @(negedge clk);
      exp = one ? s : model(s, m, lw, i);
      check((i == 0) ? "R2" : tag, word_addr, exp);
      check((i == 0) ? "R2" : "R3", 32'(burst_valid), 32'd1);
      check("R9", 32'(single_word), 32'(sw));
      check("R10", 32'(term_first), 32'(tf));
      @(posedge clk); #1;
      advance = 1'b0;
      if (adv) begin
        i++;
        if (one) begin
          @(negedge clk);
          check(tf ? "R10" : "R9", 32'(burst_valid), 32'd0);
          @(posedge clk); #1;
          break;
        end
      end
    end
  endtask

  // zero start offset: every ordering must match plain counting
  task automatic zero_offset(input logic [31:0] s, input logic [1:0] m, input int lw);
    start = 1'b1; start_addr = s; order_sel = m; line_words = 6'(lw);
    @(posedge clk); #1;
    start = 1'b0; advance = 1'b1;
    for (int i = 0; i < 2 * lw + 2; i++) begin
      @(negedge clk);
      check("R8", word_addr, s + 32'(i));
      @(posedge clk); #1;
    end
    advance = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; start = 1'b0; start_addr = '0; order_sel = '0;
    line_words = 6'd8; advance = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", 32'(burst_valid), 32'd0);
    check("R1", 32'(single_word), 32'd0);
    check("R1", 32'(term_first), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 32'(burst_valid), 32'd0);
    @(posedge clk); #1;

    // directed: nonzero offsets over several lines
    run_burst(32'h0000_0105, 2'b10, 8, 20, "R5");
    run_burst(32'h0000_0105, 2'b01, 8, 20, "R6");
    run_burst(32'h0000_0105, 2'b00, 8, 20, "R4");
    run_burst(32'h0000_2013, 2'b10, 32, 70, "R7");
    run_burst(32'h0000_2013, 2'b01, 16, 40, "R7");
    run_burst(32'h0000_0042, 2'b01, 4, 13, "R7");
    run_burst(32'hFFFF_FFFD, 2'b00, 12, 6, "R4");   // unsupported size ignored, top wrap

    // zero offset in all three orderings
    zero_offset(32'h0000_0400, 2'b00, 8);
    zero_offset(32'h0000_0400, 2'b01, 8);
    zero_offset(32'h0000_0400, 2'b10, 8);

    // unsupported size and ordering
    run_burst(32'h0000_0033, 2'b10, 12, 5, "R9");
    run_burst(32'h0000_0033, 2'b01, 0, 5, "R9");
    run_burst(32'h0000_0077, 2'b11, 8, 5, "R10");

    // advance while idle is ignored
    advance = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R11", 32'(burst_valid), 32'd0);
      @(posedge clk); #1;
    end
    advance = 1'b0;

    // restart in the middle of a burst
    run_burst(32'h0000_0901, 2'b10, 16, 5, "R5");
    run_burst(32'h0000_0A0E, 2'b01, 16, 35, "R6");

    // random mix
    for (int b = 0; b < 60; b++) begin
      logic [1:0] m  = 2'($urandom % 4);
      int         lg = 2 + int'($urandom % 4);
      int         lw = (($urandom % 8) == 0) ? int'($urandom % 64) : (1 << lg);
      logic [31:0] s = $urandom;
      string tag = (m == 2'b00) ? "R4" : (m == 2'b01) ? "R6" : (m == 2'b10) ? "R5" : "R10";
      run_burst(s, m, lw, 1 + int'($urandom % 70), tag);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule